// File: doc/BRIEF.md
# Free-Run Flat Color Generator

The block sits at the end of a video pipeline and decides, frame by frame, whether the output pixel bus carries the incoming video or a picture it makes itself. Its own timing generator runs all the time. It produces horizontal sync, vertical sync and data-enable for one of several progressive formats, picked by a format select input. When a test sets the force input, or when the input-valid flag drops, the block switches to its own timing at the next frame boundary. It then fills the active region with one flat color on three channels. When the flag recovers and force is clear, it switches back to pass-through at a frame boundary.

The fill color comes from three 8-bit manual values or from a default black that depends on the color space. Each 8-bit value is placed in the top bits of the wider output channel, and the lower bits are zero. Outside the active region, free-run output is held at the blanking level. A board self-test uses the block to drive a known picture into the downstream parts without any external source.

The control state machine has five states. BOOT lasts one cycle after reset and treats reset release as a frame start. It goes to FREE if free-run is wanted and to PASS if not. PASS moves to FREE at a frame end when free-run is wanted, and otherwise to ENTER_WAIT. ENTER_WAIT returns to PASS if the request goes away, and moves to FREE at the frame end. FREE moves to PASS at a frame end when the request is gone, and otherwise to EXIT_WAIT. EXIT_WAIT returns to FREE if the request comes back, and moves to PASS at the frame end. Free-run is wanted when force is high or input-valid is low. BOOT (when free-run is wanted), FREE and EXIT_WAIT select the generated picture. The output bus is registered, so it lags its source by one clock.

Top module: `frc_top`

## Requirements
- R1: With force_fr high at the last pixel of a generated frame, the output carries the generated picture from the next frame's first pixel on, whatever in_valid and the input bus do.
- R2: With in_valid low (force low), the block enters free-run at the next frame boundary. It returns to pass-through only at a frame boundary where force_fr is low and in_valid is high. The level that decides is the one present in the last pixel cycle of the frame.
- R3: Reset release counts as a frame start: the first pixel after reset is already generated if free-run is wanted in that cycle, and passed through otherwise.
- R4: In pass-through, out_a/b/c, out_hs, out_vs and out_de equal pin_a/b/c, pin_hs, pin_vs and pin_de of the previous clock.
- R5: In free-run with man_col=1, the active region shows col_a on out_a, col_b on out_b and col_c on out_c. Each value sits in bits [CW-1:CW-8], and bits [CW-9:0] are zero.
- R6: In free-run with man_col=0 and auto_col=1, the active color is default black. With ycbcr=1 it is 0x10 on out_a (luma/green) and 0x80 on out_b and out_c. With ycbcr=0 it is zero on all three channels. The values are MSB-aligned as in R5.
- R7: In free-run with man_col=0 and auto_col=0, all three channels are zero in the active region.
- R8: In free-run outside the active region, out_de is 0 and the channels carry blanking: 0x10/0x80/0x80 (MSB-aligned) with ycbcr=1, or zero with ycbcr=0.
- R9: Per axis, a generated frame runs active pixels from count 0, then the front porch, then the sync pulse (active high), then the back porch. out_de is high only when both axes are active.
- R10: fmt_sel=0 gives totals of 800x525, active 640x480, front porch 16/10 and sync width 96/2. fmt_sel=1 gives totals of 2200x1125, active 1920x1080, front porch 88/4 and sync width 44/5. fmt_sel=2 or 3 gives a compact 20x10 frame with 12x6 active, front porch 2/1 and sync width 3/2.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming video present |
| force_fr | input | 1 | Force the generated picture |
| man_col | input | 1 | Use the manual color values |
| auto_col | input | 1 | Use default black when manual color is off |
| ycbcr | input | 1 | Color space: 1 YCbCr, 0 RGB |
| fmt_sel | input | 2 | Generated format select |
| col_a | input | 8 | Manual value, channel A (luma/green) |
| col_b | input | 8 | Manual value, channel B |
| col_c | input | 8 | Manual value, channel C |
| pin_a | input | CW | Pass-through channel A |
| pin_b | input | CW | Pass-through channel B |
| pin_c | input | CW | Pass-through channel C |
| pin_hs | input | 1 | Pass-through horizontal sync |
| pin_vs | input | 1 | Pass-through vertical sync |
| pin_de | input | 1 | Pass-through data-enable |
| out_a | output | CW | Output channel A |
| out_b | output | CW | Output channel B |
| out_c | output | CW | Output channel C |
| out_hs | output | 1 | Output horizontal sync |
| out_vs | output | 1 | Output vertical sync |
| out_de | output | 1 | Output data-enable |

## Verification
Two events can fall in the same cycle: the generator's last pixel of a frame and a change of the free-run request. The bench provokes this by toggling force_fr exactly in the last-pixel cycle of several compact frames. It also drops and raises in_valid at random points. Its cycle model decides the mode from the request level in that last cycle and predicts every output pixel. A design that uses the level from one cycle too early or too late shows a whole frame of wrong pixels.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int AXW = 12;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_PASS,
        ST_ENTER,
        ST_FREE,
        ST_EXIT
    } frc_state_t;

    typedef struct packed {
        logic [AXW-1:0] tot;
        logic [AXW-1:0] act;
        logic [AXW-1:0] fp;
        logic [AXW-1:0] sw;
    } axis_t;

    function automatic axis_t h_axis(input logic [1:0] f);
        axis_t a;
        unique case (f)
            2'd0:    a = '{tot: 12'd800,  act: 12'd640,  fp: 12'd16, sw: 12'd96};
            2'd1:    a = '{tot: 12'd2200, act: 12'd1920, fp: 12'd88, sw: 12'd44};
            default: a = '{tot: 12'd20,   act: 12'd12,   fp: 12'd2,  sw: 12'd3};
        endcase
        return a;
    endfunction

    function automatic axis_t v_axis(input logic [1:0] f);
        axis_t a;
        unique case (f)
            2'd0:    a = '{tot: 12'd525,  act: 12'd480,  fp: 12'd10, sw: 12'd2};
            2'd1:    a = '{tot: 12'd1125, act: 12'd1080, fp: 12'd4,  sw: 12'd5};
            default: a = '{tot: 12'd10,   act: 12'd6,    fp: 12'd1,  sw: 12'd2};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/frc_timing.sv
module frc_timing
    import frc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fmt_sel,
    output logic       g_de,
    output logic       g_hs,
    output logic       g_vs,
    output logic       frame_end
);
    axis_t ht, vt;
    logic [AXW-1:0] hcnt, vcnt;
    logic line_end;

    assign ht = h_axis(fmt_sel);
    assign vt = v_axis(fmt_sel);

    assign line_end  = (hcnt >= ht.tot - 12'd1);
    assign frame_end = line_end && (vcnt >= vt.tot - 12'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
            vcnt <= (vcnt >= vt.tot - 12'd1) ? '0 : vcnt + 12'd1;
        end else begin
            hcnt <= hcnt + 12'd1;
        end
    end

    assign g_de = (hcnt < ht.act) && (vcnt < vt.act);
    assign g_hs = (hcnt >= ht.act + ht.fp) && (hcnt < ht.act + ht.fp + ht.sw);
    assign g_vs = (vcnt >= vt.act + vt.fp) && (vcnt < vt.act + vt.fp + vt.sw);
endmodule

// File: rtl/frc_color.sv
module frc_color #(
    parameter int CW = 10
) (
    input  logic          man_col,
    input  logic          auto_col,
    input  logic          ycbcr,
    input  logic          g_de,
    input  logic [7:0]    col_a,
    input  logic [7:0]    col_b,
    input  logic [7:0]    col_c,
    output logic [CW-1:0] px_a,
    output logic [CW-1:0] px_b,
    output logic [CW-1:0] px_c
);
    localparam int NCH = 3;
    localparam logic [7:0] LUMA_BLK   = 8'h10;
    localparam logic [7:0] CHROMA_MID = 8'h80;

    logic [7:0]    c8   [NCH];
    logic [CW-1:0] wide [NCH];

    always_comb begin
        if (!g_de) begin
            c8[0] = ycbcr ? LUMA_BLK   : 8'h00;
            c8[1] = ycbcr ? CHROMA_MID : 8'h00;
            c8[2] = ycbcr ? CHROMA_MID : 8'h00;
        end else if (man_col) begin
            c8[0] = col_a;
            c8[1] = col_b;
            c8[2] = col_c;
        end else if (auto_col) begin
            c8[0] = ycbcr ? LUMA_BLK   : 8'h00;
            c8[1] = ycbcr ? CHROMA_MID : 8'h00;
            c8[2] = ycbcr ? CHROMA_MID : 8'h00;
        end else begin
            c8[0] = 8'h00;
            c8[1] = 8'h00;
            c8[2] = 8'h00;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_align
        if (CW > 8) begin : g_pad
            assign wide[g] = {c8[g], {(CW-8){1'b0}}};
        end else begin : g_exact
            assign wide[g] = c8[g];
        end
    end

    assign px_a = wide[0];
    assign px_b = wide[1];
    assign px_c = wide[2];
endmodule

// File: rtl/frc_ctrl.sv
module frc_ctrl
    import frc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic frame_end,
    output logic use_gen
);
    frc_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:  nxt = want ? ST_FREE : ST_PASS;
            ST_PASS:  if (want) nxt = frame_end ? ST_FREE : ST_ENTER;
            ST_ENTER: begin
                if (!want)          nxt = ST_PASS;
                else if (frame_end) nxt = ST_FREE;
            end
            ST_FREE:  if (!want) nxt = frame_end ? ST_PASS : ST_EXIT;
            ST_EXIT:  begin
                if (want)           nxt = ST_FREE;
                else if (frame_end) nxt = ST_PASS;
            end
            default:  nxt = ST_BOOT;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_BOOT:          use_gen = want;
            ST_FREE, ST_EXIT: use_gen = 1'b1;
            default:          use_gen = 1'b0;
        endcase
    end
endmodule

// File: rtl/frc_top.sv
module frc_top #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          force_fr,
    input  logic          man_col,
    input  logic          auto_col,
    input  logic          ycbcr,
    input  logic [1:0]    fmt_sel,
    input  logic [7:0]    col_a,
    input  logic [7:0]    col_b,
    input  logic [7:0]    col_c,
    input  logic [CW-1:0] pin_a,
    input  logic [CW-1:0] pin_b,
    input  logic [CW-1:0] pin_c,
    input  logic          pin_hs,
    input  logic          pin_vs,
    input  logic          pin_de,
    output logic [CW-1:0] out_a,
    output logic [CW-1:0] out_b,
    output logic [CW-1:0] out_c,
    output logic          out_hs,
    output logic          out_vs,
    output logic          out_de
);
    logic g_de, g_hs, g_vs, gen_fe, use_gen, want;
    logic [CW-1:0] px_a, px_b, px_c;

    assign want = force_fr || !in_valid;

    frc_timing u_tim (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .g_de(g_de), .g_hs(g_hs), .g_vs(g_vs), .frame_end(gen_fe)
    );

    frc_color #(.CW(CW)) u_col (
        .man_col(man_col), .auto_col(auto_col), .ycbcr(ycbcr), .g_de(g_de),
        .col_a(col_a), .col_b(col_b), .col_c(col_c),
        .px_a(px_a), .px_b(px_b), .px_c(px_c)
    );

    frc_ctrl u_ctl (
        .clk(clk), .rst_n(rst_n), .want(want), .frame_end(gen_fe), .use_gen(use_gen)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a  <= '0;
            out_b  <= '0;
            out_c  <= '0;
            out_hs <= 1'b0;
            out_vs <= 1'b0;
            out_de <= 1'b0;
        end else if (use_gen) begin
            out_a  <= px_a;
            out_b  <= px_b;
            out_c  <= px_c;
            out_hs <= g_hs;
            out_vs <= g_vs;
            out_de <= g_de;
        end else begin
            out_a  <= pin_a;
            out_b  <= pin_b;
            out_c  <= pin_c;
            out_hs <= pin_hs;
            out_vs <= pin_vs;
            out_de <= pin_de;
        end
    end
endmodule

// File: rtl/frc_chk.sv
module frc_chk #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          use_gen,
    input logic          gen_fe,
    input logic          force_fr,
    input logic          ycbcr,
    input logic [CW-1:0] pin_a,
    input logic          pin_hs,
    input logic          pin_de,
    input logic [CW-1:0] out_a,
    input logic [CW-1:0] out_b,
    input logic [CW-1:0] out_c,
    input logic          out_hs,
    input logic          out_de
);
    logic arm1, arm2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm1 <= 1'b0;
            arm2 <= 1'b0;
        end else begin
            arm1 <= 1'b1;
            arm2 <= arm1;
        end
    end

    // R1
    force_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_fr && gen_fe) |=> use_gen);

    // R2
    mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm2 && (use_gen != $past(use_gen))) |-> $past(gen_fe));

    // R4
    pass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm1 && !$past(use_gen)) |->
        (out_a == $past(pin_a) && out_hs == $past(pin_hs) && out_de == $past(pin_de)));

    // R8
    rgb_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm1 && $past(use_gen) && !$past(ycbcr) && !out_de) |->
        (out_a == '0 && out_b == '0 && out_c == '0));

    // R9
    no_sync_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm1 && $past(use_gen) && out_de) |-> !out_hs);

    if (CW > 8) begin : g_low
        // R5
        low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (arm1 && $past(use_gen)) |->
            (out_a[CW-9:0] == '0 && out_b[CW-9:0] == '0 && out_c[CW-9:0] == '0));
    end
endmodule

bind frc_top frc_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .use_gen(use_gen), .gen_fe(gen_fe),
    .force_fr(force_fr), .ycbcr(ycbcr), .pin_a(pin_a), .pin_hs(pin_hs), .pin_de(pin_de),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_hs(out_hs), .out_de(out_de)
);

// File: tb/sim_frc_top.sv
module sim_frc_top;
    localparam int CW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b1, force_fr = 1'b0, man_col = 1'b0, auto_col = 1'b1, ycbcr = 1'b1;
    logic [1:0] fmt_sel = 2'd2;
    logic [7:0] col_a = '0, col_b = '0, col_c = '0;
    logic [CW-1:0] pin_a = '0, pin_b = '0, pin_c = '0;
    logic pin_hs = 1'b0, pin_vs = 1'b0, pin_de = 1'b0;
    logic [CW-1:0] out_a, out_b, out_c;
    logic out_hs, out_vs, out_de;

    int n_chk = 0, n_fail = 0;
    int mh, mv;
    bit mfree, mboot;

    always #5 clk = ~clk;

    frc_top #(.CW(CW)) u0 (.*);

    function automatic int tab(input int f, input int ax, input int fld);
        int t [3][2][4] = '{
            '{'{800, 640, 16, 96},   '{525, 480, 10, 2}},
            '{'{2200, 1920, 88, 44}, '{1125, 1080, 4, 5}},
            '{'{20, 12, 2, 3},       '{10, 6, 1, 2}}};
        return t[(f > 2) ? 2 : f][ax][fld];
    endfunction

    function automatic logic [CW-1:0] w8(input logic [7:0] x);
        logic [CW-1:0] r = '0;
        r[CW-1 -: 8] = x;
        return r;
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input logic [3*CW+2:0] act, input logic [3*CW+2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (h=%0d v=%0d)", req, act, exp, mh, mv);
        end
    endtask

    // One clock: expected outputs from the current inputs and the model, then compare.
    task automatic cyc;
        int f = int'(fmt_sel);
        int htot = tab(f,0,0), hact = tab(f,0,1), hfp = tab(f,0,2), hsw = tab(f,0,3);
        int vtot = tab(f,1,0), vact = tab(f,1,1), vfp = tab(f,1,2), vsw = tab(f,1,3);
        bit want = force_fr || !in_valid;
        bit fe = (mh == htot-1) && (mv == vtot-1);
        bit sel = mboot ? want : mfree;
        logic [CW-1:0] ea, eb, ec;
        logic ehs, evs, ede;
        string tg_t, tg_c;
        if (sel) begin
            ede = (mh < hact) && (mv < vact);
            ehs = (mh >= hact+hfp) && (mh < hact+hfp+hsw);
            evs = (mv >= vact+vfp) && (mv < vact+vfp+vsw);
            tg_t = "R9/R10";
            if (!ede) begin
                tg_c = "R8";
                ea = ycbcr ? w8(8'h10) : '0; eb = ycbcr ? w8(8'h80) : '0; ec = eb;
            end else if (man_col) begin
                tg_c = "R5";
                ea = w8(col_a); eb = w8(col_b); ec = w8(col_c);
            end else if (auto_col) begin
                tg_c = "R6";
                ea = ycbcr ? w8(8'h10) : '0; eb = ycbcr ? w8(8'h80) : '0; ec = eb;
            end else begin
                tg_c = "R7";
                ea = '0; eb = '0; ec = '0;
            end
        end else begin
            tg_t = "R4"; tg_c = "R4";
            ea = pin_a; eb = pin_b; ec = pin_c; ehs = pin_hs; evs = pin_vs; ede = pin_de;
        end
        if (mboot) begin tg_t = {tg_t, " R3"}; tg_c = {tg_c, " R3"}; end
        else if (fe) begin tg_t = {tg_t, " R1/R2"}; end
        mfree = mboot ? want : (fe ? want : mfree);
        mboot = 1'b0;
        @(negedge clk);
        chk(tg_t, {3'b000, {3*CW{1'b0}}} | {out_hs, out_vs, out_de, {3*CW{1'b0}}},
                  {ehs, evs, ede, {3*CW{1'b0}}});
        chk(tg_c, {3'b000, out_a, out_b, out_c}, {3'b000, ea, eb, ec});
        if (mh == htot-1) begin
            mh = 0;
            mv = (mv == vtot-1) ? 0 : mv + 1;
        end else mh++;
    endtask

    task automatic rnd_pins;
        pin_a = CW'($urandom); pin_b = CW'($urandom); pin_c = CW'($urandom);
        pin_hs = 1'($urandom); pin_vs = 1'($urandom); pin_de = 1'($urandom);
    endtask

    task automatic rnd_color;
        man_col = 1'($urandom); auto_col = 1'($urandom); ycbcr = 1'($urandom);
        col_a = 8'($urandom); col_b = 8'($urandom); col_c = 8'($urandom);
    endtask

    // R11: outputs zero under reset, then release with the model at frame start.
    task automatic do_reset(input logic [1:0] f);
        rst_n = 1'b0;
        fmt_sel = f;
        for (int i = 0; i < 3; i++) begin
            rnd_pins();
            @(negedge clk);
            chk("R11", {3'b000, out_a, out_b, out_c} | {out_hs, out_vs, out_de, {3*CW{1'b0}}}, '0);
        end
        rst_n = 1'b1;
        mh = 0; mv = 0; mfree = 1'b0; mboot = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset(2'd2);

        // R3, R4: pass-through from the first pixel
        force_fr = 1'b0; in_valid = 1'b1;
        for (int i = 0; i < 60; i++) begin rnd_pins(); cyc(); end

        // R2: input loss, colors varied
        in_valid = 1'b0;
        for (int i = 0; i < 600; i++) begin
            if (i % 37 == 0) rnd_color();
            rnd_pins(); cyc();
        end

        // R1: force with in_valid toggling every cycle
        force_fr = 1'b1;
        for (int i = 0; i < 400; i++) begin
            in_valid = 1'($urandom); rnd_pins(); cyc();
        end

        // R1/R2 corner: request toggles exactly in the last pixel of a frame
        force_fr = 1'b0; in_valid = 1'b1;
        man_col = 1'b1; col_a = 8'hFF; col_b = 8'h01; col_c = 8'h5A;
        for (int i = 0; i < 1600; i++) begin
            if (mh == tab(2,0,0)-1 && mv == tab(2,1,0)-1) force_fr = ~force_fr;
            rnd_pins(); cyc();
        end

        // R5-R8: mixed random traffic with rare request changes
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(49) == 0) force_fr = 1'($urandom);
            if ($urandom_range(49) == 0) in_valid = 1'($urandom);
            if ($urandom_range(19) == 0) rnd_color();
            rnd_pins(); cyc();
        end

        // R3, R10: full-size formats, forced from reset, two lines each
        force_fr = 1'b1; man_col = 1'b0; auto_col = 1'b1; ycbcr = 1'b1;
        do_reset(2'd0);
        for (int i = 0; i < 1700; i++) begin rnd_pins(); cyc(); end
        do_reset(2'd1);
        for (int i = 0; i < 4500; i++) begin rnd_pins(); cyc(); end

        // R3: reset with free-run not wanted passes the first pixel
        force_fr = 1'b0; in_valid = 1'b1;
        do_reset(2'd3);
        for (int i = 0; i < 50; i++) begin rnd_pins(); cyc(); end

        report();
    end
endmodule